// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block follows a circular list of transmit descriptors held in a small descriptor memory. Each descriptor is eight bytes. It holds a control halfword, a 16-bit octet count and a 32-bit buffer address. The block reads a descriptor in four halfword reads. If hardware owns the descriptor, it reads the stated number of octets from a byte-wide buffer memory and presents them on a valid/ready output. It then writes the control halfword back and moves on to the next descriptor.

When software has not yet handed over a descriptor, the walker parks on it until a poll pulse arrives. Three flags shape the close:
- The continuous flag keeps a descriptor owned by hardware, so the buffer is sent again on every visit.
- The wrap flag sends the walk back to the programmed ring base.
- The interrupt flag produces a per-buffer event. The events accumulate in a counter, and the counter raises a sticky global interrupt at a programmable threshold.

A zero octet count is closed as an error. A walk that would run past the permitted ring span is sent back to the base and flagged.

Top module: `txd_ring_walker`

## Requirements
- R1: After reset, tx_valid, dm_rd, dm_wr, close_valid and global_irq are low. The walker issues no descriptor read until poll is pulsed.
- R2: A fetch reads the control halfword at the descriptor address, the length at +2, the upper pointer half at +4 and the lower pointer half at +6. Control bit 15 is Ready, bit 13 is Wrap, bit 12 is Interrupt and bit 9 is Continuous.
- R3: If the fetched control halfword has Ready at 0, the walker sends no octets and writes nothing. It stays on that descriptor and ignores the memory until a poll pulse makes it re-read the same address.
- R4: With Ready at 1 and a nonzero length N, exactly N octets leave on tx_data. They are read from the pointer upward in ascending order. Each octet is held stable while tx_valid is high and tx_ready is low.
- R5: On close, the walker writes only the control halfword, at the descriptor address. It clears bit 15 and keeps every other bit. The length and pointer halfwords are never written.
- R6: With Continuous set and a nonzero length, the written-back control keeps bit 15 at 1, and the buffer is sent again on the next visit.
- R7: After a close, the walker fetches the next descriptor without a poll. The next descriptor is at the ring base if Wrap is set, and at the current address plus 8 otherwise.
- R8: A length of zero gives a close with close_err high and no octets. Bit 15 is written back as 0 even when Continuous is set.
- R9: A close of a descriptor with Interrupt set pulses buf_event once and increments the event counter. global_irq goes high the cycle after the counter reaches irq_thresh.
- R10: global_irq stays high until irq_clear. irq_clear resets the counter to zero. An event in the same cycle as irq_clear is counted after the clear.
- R11: If the descriptor after a non-wrapping close would end beyond SPAN_BYTES from the ring base, span_err pulses with that close and the next fetch is at the ring base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | AW | Byte address of the first descriptor |
| poll | input | 1 | Pulse that restarts a parked walker |
| irq_thresh | input | CW | Event count that raises global_irq |
| irq_clear | input | 1 | Write-one pulse clearing global_irq and the counter |
| dm_rd | output | 1 | Descriptor memory read strobe |
| dm_wr | output | 1 | Descriptor memory write strobe |
| dm_addr | output | AW | Descriptor memory byte address (halfword aligned) |
| dm_wdata | output | 16 | Control halfword written back |
| dm_rdata | input | 16 | Read data, one cycle after dm_rd |
| bm_rd | output | 1 | Buffer memory read strobe |
| bm_addr | output | 32 | Buffer memory byte address |
| bm_rdata | input | 8 | Buffer octet, one cycle after bm_rd |
| tx_valid | output | 1 | Output octet valid |
| tx_data | output | 8 | Output octet |
| tx_ready | input | 1 | Sink accepts the octet |
| close_valid | output | 1 | Pulse in the write-back cycle |
| close_err | output | 1 | Close caused by a zero length |
| buf_event | output | 1 | Per-buffer interrupt event |
| span_err | output | 1 | Ring span limit hit on this close |
| global_irq | output | 1 | Sticky global interrupt |

## Verification
A per-buffer event and a software clear of the global interrupt can fall in the same cycle. The bench provokes this by tying irq_clear to buf_event during one close, with the counter already holding one event and a threshold of two. The rule is judged by global_irq: it must stay low after that close, which proves the counter restarted from zero. It must rise after the following event, which proves the colliding event was counted. A close and the span check also coincide, and the bench judges that through span_err and the address of the next control fetch.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int CTRL_W     = 16;
    localparam int BIT_READY  = 15;
    localparam int BIT_WRAP   = 13;
    localparam int BIT_INTR   = 12;
    localparam int BIT_CONT   = 9;
    localparam int DESC_BYTES = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FC,
        S_WC,
        S_WL,
        S_WPH,
        S_WPL,
        S_BRD,
        S_BDAT,
        S_TX,
        S_CLOSE
    } walk_st_e;

    typedef struct packed {
        logic ready;
        logic wrap;
        logic intr;
        logic cont;
    } ctrl_flags_t;

    function automatic ctrl_flags_t decode_ctrl(input logic [CTRL_W-1:0] h);
        ctrl_flags_t f;
        f.ready = h[BIT_READY];
        f.wrap  = h[BIT_WRAP];
        f.intr  = h[BIT_INTR];
        f.cont  = h[BIT_CONT];
        return f;
    endfunction

    function automatic logic [CTRL_W-1:0] close_word(input logic [CTRL_W-1:0] h,
                                                     input logic err);
        logic [CTRL_W-1:0] w;
        w = h;
        w[BIT_READY] = h[BIT_READY] & h[BIT_CONT] & ~err;
        return w;
    endfunction

endpackage

// File: rtl/twr_ring_step.sv
module twr_ring_step #(
    parameter int SPAN_BYTES = 65536,
    parameter int OW         = $clog2(SPAN_BYTES) + 1
) (
    input  logic [OW-1:0] cur_off,
    input  logic          wrap,
    output logic [OW-1:0] next_off,
    output logic          span_hit
);
    import txd_pkg::*;

    logic [OW-1:0] stepped;

    always_comb begin
        stepped  = cur_off + OW'(DESC_BYTES);
        span_hit = !wrap && ((32'(stepped) + 32'(DESC_BYTES)) > 32'(SPAN_BYTES));
        next_off = (wrap || span_hit) ? '0 : stepped;
    end
endmodule

// File: rtl/twr_irq_count.sv
module twr_irq_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evt,
    input  logic          clr,
    input  logic [CW-1:0] thresh,
    output logic          gint
);
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] count;
    logic [CW-1:0] base_cnt;
    logic [CW-1:0] new_cnt;

    always_comb begin
        base_cnt = clr ? '0 : count;
        new_cnt  = base_cnt;
        if (evt && base_cnt != CMAX)
            new_cnt = base_cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            gint  <= 1'b0;
        end else begin
            count <= new_cnt;
            gint  <= (gint && !clr) || (evt && new_cnt >= thresh);
        end
    end

    // R10: flag is sticky without a clear
    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        gint && !clr |=> gint);
    // R10: a clear with no event leaves flag and counter at zero
    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clr && !evt |=> !gint && count == '0);
    // R9: the flag only rises after an event
    p_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(gint) |-> $past(evt));
endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker #(
    parameter int AW         = 16,
    parameter int CW         = 8,
    parameter int SPAN_BYTES = 65536
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ring_base,
    input  logic          poll,
    input  logic [CW-1:0] irq_thresh,
    input  logic          irq_clear,
    output logic          dm_rd,
    output logic          dm_wr,
    output logic [AW-1:0] dm_addr,
    output logic [15:0]   dm_wdata,
    input  logic [15:0]   dm_rdata,
    output logic          bm_rd,
    output logic [31:0]   bm_addr,
    input  logic [7:0]    bm_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    input  logic          tx_ready,
    output logic          close_valid,
    output logic          close_err,
    output logic          buf_event,
    output logic          span_err,
    output logic          global_irq
);
    import txd_pkg::*;

    localparam int OW = $clog2(SPAN_BYTES) + 1;

    walk_st_e      st;
    logic [OW-1:0] off;
    logic [15:0]   ctrl;
    logic [15:0]   len;
    logic [31:0]   ptr;
    logic [15:0]   cnt;
    logic [7:0]    txd;
    logic          txv;
    logic [2:0]    step;
    ctrl_flags_t   flags;
    logic [OW-1:0] next_off;
    logic          span_hit;

    assign flags = decode_ctrl(ctrl);

    twr_ring_step #(.SPAN_BYTES(SPAN_BYTES), .OW(OW)) u_step (
        .cur_off  (off),
        .wrap     (flags.wrap),
        .next_off (next_off),
        .span_hit (span_hit)
    );

    twr_irq_count #(.CW(CW)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .evt    (buf_event),
        .clr    (irq_clear),
        .thresh (irq_thresh),
        .gint   (global_irq)
    );

    always_comb begin
        step = 3'd0;
        case (st)
            S_WC:    step = 3'd2;
            S_WL:    step = 3'd4;
            S_WPH:   step = 3'd6;
            default: step = 3'd0;
        endcase
        dm_addr     = ring_base + AW'(off) + AW'(step);
        dm_rd       = (st == S_FC) || (st == S_WL) || (st == S_WPH) ||
                      (st == S_WC && dm_rdata[BIT_READY]);
        close_valid = (st == S_CLOSE);
        close_err   = close_valid && (len == 16'd0);
        dm_wr       = close_valid;
        dm_wdata    = close_word(ctrl, len == 16'd0);
        buf_event   = close_valid && flags.intr;
        span_err    = close_valid && span_hit;
        bm_rd       = (st == S_BRD);
        bm_addr     = ptr + 32'(cnt);
        tx_valid    = txv;
        tx_data     = txd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            off  <= '0;
            ctrl <= '0;
            len  <= '0;
            ptr  <= '0;
            cnt  <= '0;
            txd  <= '0;
            txv  <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (poll) st <= S_FC;
                S_FC:   st <= S_WC;
                S_WC: begin
                    if (dm_rdata[BIT_READY]) begin
                        ctrl <= dm_rdata;
                        st   <= S_WL;
                    end else begin
                        st <= S_IDLE;
                    end
                end
                S_WL: begin
                    len <= dm_rdata;
                    st  <= S_WPH;
                end
                S_WPH: begin
                    ptr[31:16] <= dm_rdata;
                    st         <= S_WPL;
                end
                S_WPL: begin
                    ptr[15:0] <= dm_rdata;
                    cnt       <= '0;
                    st        <= (len == 16'd0) ? S_CLOSE : S_BRD;
                end
                S_BRD:  st <= S_BDAT;
                S_BDAT: begin
                    txd <= bm_rdata;
                    txv <= 1'b1;
                    st  <= S_TX;
                end
                S_TX: begin
                    if (tx_ready) begin
                        txv <= 1'b0;
                        cnt <= cnt + 16'd1;
                        st  <= (cnt + 16'd1 == len) ? S_CLOSE : S_BRD;
                    end
                end
                S_CLOSE: begin
                    off <= next_off;
                    st  <= S_FC;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R4: an octet waiting for the sink is held
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
    // R5: descriptor memory is never read and written in one cycle
    p_rw_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(dm_rd && dm_wr));
    // R8: an error close never coincides with an octet on the output
    p_err_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        close_err |-> !tx_valid && !bm_rd);
    // R11: the span flag only comes with a close, and a fetch follows
    p_span_r11: assert property (@(posedge clk) disable iff (rst)
        span_err |=> dm_rd && dm_addr == ring_base);
    // R7: every close is followed by a control fetch with no poll
    p_next_r7: assert property (@(posedge clk) disable iff (rst)
        close_valid |=> dm_rd && !dm_wr);
endmodule

// File: tb/txd_ring_walker_bench.sv
module txd_ring_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SPAN       = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ring_base = '0;
    logic        poll = 1'b0;
    logic [7:0]  irq_thresh = 8'd1;
    logic        clr_drv = 1'b0;
    logic        collide = 1'b0;
    logic        irq_clear;
    logic        dm_rd, dm_wr;
    logic [15:0] dm_addr, dm_wdata, dm_rdata;
    logic        bm_rd;
    logic [31:0] bm_addr;
    logic [7:0]  bm_rdata;
    logic        tx_valid, tx_ready;
    logic [7:0]  tx_data;
    logic        close_valid, close_err, buf_event, span_err, global_irq;
    logic        bp_mode = 1'b0;

    logic [15:0] dmem [0:63];
    logic [7:0]  got [0:255];
    int          n_bytes, n_close, n_err, n_evt, n_span, n_wr, n_rd;
    logic [15:0] last_ctrl;
    logic        mon_clr = 1'b0;
    int          checks = 0, errors = 0, cyc = 0;

    assign irq_clear = clr_drv | (collide & buf_event);

    txd_ring_walker #(.AW(16), .CW(8), .SPAN_BYTES(SPAN)) u_txd_ring_walker (
        .clk(clk), .rst(rst), .ring_base(ring_base), .poll(poll),
        .irq_thresh(irq_thresh), .irq_clear(irq_clear),
        .dm_rd(dm_rd), .dm_wr(dm_wr), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
        .dm_rdata(dm_rdata), .bm_rd(bm_rd), .bm_addr(bm_addr), .bm_rdata(bm_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .close_valid(close_valid), .close_err(close_err), .buf_event(buf_event),
        .span_err(span_err), .global_irq(global_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] bval(input logic [31:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (dm_rd) dm_rdata <= dmem[dm_addr[6:1]];
        if (dm_wr) dmem[dm_addr[6:1]] <= dm_wdata;
        if (bm_rd) bm_rdata <= bval(bm_addr);
    end

    always @(negedge clk) tx_ready <= bp_mode ? ~tx_ready : 1'b1;

    always @(posedge clk) begin
        if (mon_clr) begin
            n_bytes <= 0; n_close <= 0; n_err <= 0; n_evt <= 0;
            n_span <= 0; n_wr <= 0; n_rd <= 0; last_ctrl <= 16'hFFFF;
        end else begin
            if (tx_valid && tx_ready) begin
                if (n_bytes < 256) got[n_bytes] <= tx_data;
                n_bytes <= n_bytes + 1;
            end
            if (close_valid) n_close <= n_close + 1;
            if (close_err)   n_err <= n_err + 1;
            if (buf_event)   n_evt <= n_evt + 1;
            if (span_err)    n_span <= n_span + 1;
            if (dm_wr)       n_wr <= n_wr + 1;
            if (dm_rd)       n_rd <= n_rd + 1;
            if (dm_rd && dm_addr[2:0] == 3'd0) last_ctrl <= dm_addr;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            $display("FAIL watchdog: act %0d cycles exp fewer", cyc);
            errors = errors + 1;
            checks = checks + 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act %0h exp %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [15:0] base);
        @(negedge clk);
        rst = 1'b1; mon_clr = 1'b1; ring_base = base;
        clr_drv = 1'b0; collide = 1'b0; bp_mode = 1'b0; poll = 1'b0;
        for (int i = 0; i < 64; i++) dmem[i] = 16'h0000;
        wait_cyc(3);
        rst = 1'b0; mon_clr = 1'b0;
    endtask

    task automatic put_desc(input int byte_addr, input logic [15:0] c,
                            input logic [15:0] l, input logic [31:0] p);
        dmem[byte_addr/2]     = c;
        dmem[byte_addr/2 + 1] = l;
        dmem[byte_addr/2 + 2] = p[31:16];
        dmem[byte_addr/2 + 3] = p[15:0];
    endtask

    task automatic pulse_poll();
        poll = 1'b1; wait_cyc(1); poll = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(16'd0);
        put_desc(0, 16'h8000, 16'd1, 32'h10);
        wait_cyc(20);
        check("R1 tx_valid", {31'd0, tx_valid}, 0);
        check("R1 global_irq", {31'd0, global_irq}, 0);
        check("R1 no reads", n_rd, 0);
        check("R1 no closes", n_close, 0);
    endtask

    task automatic t_not_ready();
        do_reset(16'd0);
        put_desc(0, 16'h0000, 16'd2, 32'h20);
        pulse_poll();
        wait_cyc(30);
        check("R3 no bytes", n_bytes, 0);
        check("R3 no writes", n_wr, 0);
        check("R3 parked address", {16'd0, last_ctrl}, 0);
        dmem[0] = 16'h8000;
        wait_cyc(30);
        check("R3 waits for poll", n_close, 0);
        pulse_poll();
        wait_cyc(40);
        check("R3 poll resumes", n_close, 1);
        check("R3 bytes after poll", n_bytes, 2);
    endtask

    task automatic t_basic(input logic bp);
        do_reset(16'd0);
        bp_mode = bp;
        put_desc(0, 16'h8000, 16'd3, 32'h0000_0100);
        pulse_poll();
        wait_cyc(80);
        check("R4 byte count", n_bytes, 3);
        for (int i = 0; i < 3; i++)
            check("R4 byte value", {24'd0, got[i]}, {24'd0, bval(32'h100 + i)});
        check("R5 ready cleared", {16'd0, dmem[0]}, 32'h0000);
        check("R5 length kept", {16'd0, dmem[1]}, 3);
        check("R5 ptr hi kept", {16'd0, dmem[2]}, 0);
        check("R5 ptr lo kept", {16'd0, dmem[3]}, 32'h100);
        check("R5 one write", n_wr, 1);
        check("R7 next at +8", {16'd0, last_ctrl}, 8);
        check("R2 read count", n_rd, 5);
    endtask

    task automatic t_wrap();
        do_reset(16'd16);
        put_desc(16, 16'hA000, 16'd1, 32'h0000_0030);
        pulse_poll();
        wait_cyc(40);
        check("R7 wrap to base", {16'd0, last_ctrl}, 16);
        check("R2 other bits kept", {16'd0, dmem[8]}, 32'h2000);
        check("R7 single close", n_close, 1);
    endtask

    task automatic t_cont();
        do_reset(16'd0);
        put_desc(0, 16'hA200, 16'd2, 32'h0000_0040);
        pulse_poll();
        wait_cyc(60);
        check("R6 resent", {31'd0, n_bytes >= 4}, 1);
        check("R6 byte 2", {24'd0, got[2]}, {24'd0, bval(32'h40)});
        check("R6 byte 3", {24'd0, got[3]}, {24'd0, bval(32'h41)});
        check("R6 ready kept", {16'd0, dmem[0]}, 32'hA200);
    endtask

    task automatic t_zero();
        do_reset(16'd0);
        irq_thresh = 8'd5;
        put_desc(0, 16'h9200, 16'd0, 32'h50);
        pulse_poll();
        wait_cyc(30);
        check("R8 error close", n_err, 1);
        check("R8 no octets", n_bytes, 0);
        check("R8 ready cleared with cont", {16'd0, dmem[0]}, 32'h1200);
        check("R9 event on error", n_evt, 1);
        check("R8 next at +8", {16'd0, last_ctrl}, 8);
    endtask

    task automatic t_irq();
        do_reset(16'd0);
        irq_thresh = 8'd3;
        put_desc(0, 16'h9000, 16'd1, 32'h60);
        put_desc(8, 16'h9000, 16'd1, 32'h61);
        pulse_poll();
        wait_cyc(50);
        check("R9 two events", n_evt, 2);
        check("R9 below threshold", {31'd0, global_irq}, 0);
        put_desc(16, 16'h9000, 16'd1, 32'h62);
        pulse_poll();
        wait_cyc(40);
        check("R9 at threshold", {31'd0, global_irq}, 1);
        wait_cyc(10);
        check("R10 sticky", {31'd0, global_irq}, 1);
        clr_drv = 1'b1; wait_cyc(1); clr_drv = 1'b0;
        wait_cyc(2);
        check("R10 cleared", {31'd0, global_irq}, 0);
        put_desc(24, 16'h9000, 16'd1, 32'h63);
        pulse_poll();
        wait_cyc(40);
        check("R10 counter restarted", {31'd0, global_irq}, 0);
    endtask

    task automatic t_collide();
        do_reset(16'd0);
        irq_thresh = 8'd2;
        put_desc(0, 16'h9000, 16'd1, 32'h70);
        pulse_poll();
        wait_cyc(40);
        check("R10 one event", {31'd0, global_irq}, 0);
        collide = 1'b1;
        put_desc(8, 16'h9000, 16'd1, 32'h71);
        pulse_poll();
        wait_cyc(40);
        collide = 1'b0;
        check("R10 clear with event", {31'd0, global_irq}, 0);
        put_desc(16, 16'h9000, 16'd1, 32'h72);
        pulse_poll();
        wait_cyc(40);
        check("R10 colliding event counted", {31'd0, global_irq}, 1);
    endtask

    task automatic t_span();
        do_reset(16'd0);
        for (int i = 0; i < SPAN / 8; i++)
            put_desc(i * 8, 16'h8000, 16'd1, 32'h80 + i);
        pulse_poll();
        wait_cyc(200);
        check("R11 span flagged", n_span, 1);
        check("R11 back at base", {16'd0, last_ctrl}, 0);
        check("R11 all sent", n_bytes, SPAN / 8);
    endtask

    initial begin
        t_reset();
        t_not_ready();
        t_basic(1'b0);
        t_basic(1'b1);
        t_wrap();
        t_cont();
        t_zero();
        t_irq();
        t_collide();
        t_span();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule